// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block decides which external memory device answers a transaction. It holds four programmable windows, one per chip select. Each window has a lower bound, an upper bound and an enable flag. On every valid request the address is tested against all enabled windows, and the chosen active-low select line is driven low for one cycle. Windows can sit anywhere in the address space, and gaps between them are allowed. An address that no enabled window covers drives no select line. Instead it raises a one-cycle select error and sets a sticky error flag.

Software sets up the windows and the enables through a small write port. It then reads the faulting address from `err_addr`. It acknowledges the fault by writing a one to the clear command. Bounds are compared at 16 MB granularity on address bits [31:24], and both bounds are inclusive.

Top module: `csdec`

## Requirements
- R1: After reset all enables are clear and `cs_n` is all ones, `err_pulse` and `err_sticky` are 0, so any request before configuration produces a select error.
- R2: A write with `cfg_kind`=0 sets the lower bound of bank `cfg_bank`, `cfg_kind`=1 sets its upper bound, and `cfg_kind`=2 sets its enable from `cfg_wdata[0]`. Bounds are the value of address bits [31:24].
- R3: When a valid request's bits [31:24] lie between an enabled bank's lower and upper bound, inclusive, `cs_n` bit i (bank i) is low in the cycle after the request.
- R4: A disabled bank never drives its select and never hides an error, even when its window covers the address.
- R5: When enabled windows overlap, the lowest-numbered bank wins. At most one `cs_n` bit is low in any cycle.
- R6: A valid request that no enabled bank claims gives `err_pulse`=1 for one cycle in the next cycle, with `cs_n` all ones, and sets `err_sticky`.
- R7: `err_addr` captures the full address of the first miss and keeps it while `err_sticky` is set. Later misses do not overwrite it.
- R8: A write with `cfg_kind`=3 and `cfg_wdata[0]`=1 clears `err_sticky`. The same write with `cfg_wdata[0]`=0 has no effect. A miss in the same cycle as the clear wins and is captured.
- R9: Without a valid request, `cs_n` is all ones and `err_pulse` is 0 in the following cycle.
- R10: Windows need not be contiguous. Addresses in a gap between two enabled windows miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 lower bound, 1 upper bound, 2 enable, 3 error clear |
| cfg_bank | input | 2 | Bank index of the write |
| cfg_wdata | input | 8 | Bound value or flag in bit 0 |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| cs_n | output | 4 | Registered active-low chip selects |
| err_pulse | output | 1 | Registered one-cycle select error |
| err_sticky | output | 1 | Sticky error status |
| err_addr | output | 32 | First faulting address |

## Verification
Addresses are placed exactly on every lower and upper bound and one step outside them. This separates inclusive bounds from exclusive ones and tests the 16 MB granularity. Requests inside an overlap of two enabled windows show whether the lowest-numbered bank wins. Requests inside a disabled bank that spans everything show whether the enable gates decoding. A run of misses followed by clear writes of 0 and 1 shows whether the first fault is kept and how the clear acts.

// File: rtl/csdec.sv
module csdec #(
  parameter int NBANK = 4,
  parameter int AW    = 32,
  parameter int HI    = 31,
  parameter int LO    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [$clog2(NBANK)-1:0] cfg_bank,
  input  logic [HI-LO:0]   cfg_wdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic [NBANK-1:0] cs_n,
  output logic             err_pulse,
  output logic             err_sticky,
  output logic [AW-1:0]    err_addr
);
  localparam int MW = HI - LO + 1;

  logic [MW-1:0]    lo_q [NBANK];
  logic [MW-1:0]    hi_q [NBANK];
  logic [NBANK-1:0] en_q;
  logic [NBANK-1:0] hit, pick;
  logic [MW-1:0]    seg;
  logic             miss, clr;

  assign seg  = req_addr[HI:LO];
  assign clr  = cfg_we && cfg_kind == 2'd3 && cfg_wdata[0];
  assign miss = req_valid && !(|hit);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign hit[i] = en_q[i] && seg >= lo_q[i] && seg <= hi_q[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
        en_q[i] <= 1'b0;
      end else if (cfg_we && cfg_bank == i) begin
        if (cfg_kind == 2'd0) lo_q[i] <= cfg_wdata;
        if (cfg_kind == 2'd1) hi_q[i] <= cfg_wdata;
        if (cfg_kind == 2'd2) en_q[i] <= cfg_wdata[0];
      end
  end

  always_comb begin
    pick = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (hit[i]) pick = NBANK'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_n       <= '1;
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      err_addr   <= '0;
    end else begin
      cs_n      <= req_valid ? ~pick : '1;
      err_pulse <= miss;
      if (miss) err_sticky <= 1'b1;
      else if (clr) err_sticky <= 1'b0;
      if (miss && (!err_sticky || clr)) err_addr <= req_addr;
    end
endmodule

module csdec_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_kind,
  input logic             clr_bit,
  input logic             req_valid,
  input logic [NBANK-1:0] cs_n,
  input logic             err_pulse,
  input logic             err_sticky,
  input logic [AW-1:0]    err_addr
);
  // R5
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R6
  err_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (&cs_n) && err_sticky);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&cs_n) && !err_pulse);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky && !(cfg_we && cfg_kind == 2'd3 && clr_bit) |=> $stable(err_addr));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd3 && clr_bit && !req_valid) |=> !err_sticky);
endmodule

bind csdec csdec_chk #(.NBANK(NBANK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
  .clr_bit(cfg_wdata[0]), .req_valid(req_valid), .cs_n(cs_n),
  .err_pulse(err_pulse), .err_sticky(err_sticky), .err_addr(err_addr)
);

// File: tb/test_csdec.sv
module test_csdec;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_kind = 0;
  logic [1:0]  cfg_bank = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [3:0]  cs_n;
  logic        err_pulse, err_sticky;
  logic [31:0] err_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csdec i_csdec (.*);

  // {addr, expected cs_n, expected err_pulse}
  localparam logic [36:0] VEC [11] = '{
    {32'h1000_0000, 4'b1110, 1'b0},  // R3 lower bound bank0
    {32'h1FFF_FFFF, 4'b1110, 1'b0},  // R3 upper bound bank0
    {32'h2000_0000, 4'b1101, 1'b0},  // R3 bank1
    {32'h2FFF_FFFF, 4'b1101, 1'b0},  // R3 upper bound bank1
    {32'h3000_0000, 4'b1111, 1'b1},  // R4 disabled bank3 covers, still miss
    {32'h0FFF_FFFF, 4'b1111, 1'b1},  // R6 just below bank0
    {32'h8012_3456, 4'b1011, 1'b0},  // R10 isolated bank2
    {32'h7FFF_FFFF, 4'b1111, 1'b1},  // R10 gap
    {32'h8100_0000, 4'b1111, 1'b1},  // R10 above bank2
    {32'h1800_0000, 4'b1110, 1'b0},  // R5 overlap, bank0 wins
    {32'h1F00_0000, 4'b1110, 1'b0}   // R5 overlap top
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] k, logic [1:0] b, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_bank = b; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic req(logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cs_n", cs_n, 4'hF);
    check("R1 err", {err_pulse, err_sticky}, 0);
    req(32'h1000_0000);
    check("R1 unconfigured miss", {cs_n, err_pulse}, {4'hF, 1'b1});
    wr(3, 0, 1);

    wr(0, 0, 8'h10); wr(1, 0, 8'h1F); wr(2, 0, 1);   // R2
    wr(0, 1, 8'h18); wr(1, 1, 8'h2F); wr(2, 1, 1);
    wr(0, 2, 8'h80); wr(1, 2, 8'h80); wr(2, 2, 1);
    wr(0, 3, 8'h00); wr(1, 3, 8'hFF); wr(2, 3, 0);
    check("R8 clear", err_sticky, 0);

    for (int i = 0; i < 11; i++) begin
      req(VEC[i][36:5]);
      check($sformatf("R3/R5/R6 vec%0d", i), {cs_n, err_pulse}, VEC[i][4:0]);
    end
    check("R7 first fault kept", err_addr, 32'h3000_0000);
    check("R6 sticky", err_sticky, 1);

    @(negedge clk);
    check("R9 idle", {cs_n, err_pulse}, {4'hF, 1'b0});

    wr(3, 0, 0);
    check("R8 clear with 0 ignored", err_sticky, 1);
    wr(3, 0, 1);
    check("R8 clear with 1", err_sticky, 0);
    req(32'h9000_0000);
    check("R7 new capture", err_addr, 32'h9000_0000);

    @(negedge clk);
    cfg_we = 1; cfg_kind = 3; cfg_wdata = 1; req_valid = 1; req_addr = 32'hA000_0000;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R8 miss beats clear", {err_sticky, err_addr}, {1'b1, 32'hA000_0000});

    wr(2, 3, 1);
    req(32'h3000_0000);
    check("R4 enabled bank3 now selects", {cs_n, err_pulse}, {4'b0111, 1'b0});
    req(32'h1000_0000);
    check("R5 bank0 over bank3", cs_n, 4'b1110);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule